// File: doc/BRIEF.md
# Column-Compression Multiplier with Parallel Ones-Counters

This block multiplies two unsigned integers of parameterized widths (4 by 4 bits by default) and returns the full-width product. Every bit of one operand is ANDed with every bit of the other. The resulting terms are grouped by binary weight, so the column heights rise from one at the least significant end to the smaller operand width in the middle and fall back towards the top.

Each reduction stage treats every column on its own. A column of one bit is passed through unchanged. A column of two bits goes through a half adder and a column of three bits through a full adder. A taller column goes through a parallel ones-counter, which is built only from half and full adders and has no carry input or output. Bit k of a counter's count, weighted 2^k, goes to the column k places higher in the next stage. Stages repeat while any column is taller than two bits. The last two rows are then added by a carry-propagate adder.

The operands are captured in a register on a valid flag. The reduction network is purely combinational, and its result is captured in a product register that carries its own valid flag.

Top module: `pcmul_top`

## Requirements
- R1: While reset is asserted, and after it until the first valid result, out_vld is 0 and out_prod is 0.
- R2: out_vld is high exactly two rising clock edges after an edge at which in_vld was sampled high, and low two edges after an edge at which in_vld was sampled low.
- R3: When out_vld is high, out_prod equals the unsigned product of in_a and in_b as sampled two edges earlier, over all A_W+B_W bits. For the 4x4 default this holds for all 256 operand pairs.
- R4: Operands presented while in_vld is low are ignored: out_prod keeps the last valid product for as long as out_vld stays low.
- R5: A new operand pair may be accepted on every clock edge, and back-to-back pairs give one result per cycle in the order they were presented.
- R6: Extreme operands are exact: all ones times all ones gives (2^A_W-1)(2^B_W-1) without loss of the top bit, and a zero operand gives zero.
- R7: Operands with a single set bit at positions i and j give a product with exactly one set bit, at position i+j. This holds for every column of the triangle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand pair on in_a and in_b is valid |
| in_a | input | A_W | Unsigned first operand |
| in_b | input | B_W | Unsigned second operand |
| out_vld | output | 1 | out_prod holds a new product this cycle |
| out_prod | output | A_W+B_W | Unsigned product, held between results |

## Verification
A counter output bit routed to the wrong column, or given the wrong slot, corrupts only the products whose partial products fill that column. The error appears at out_prod two edges after the pair is presented. The exhaustive sweep and the single-bit operand pairs therefore point at the faulty weight directly. A wrong valid or load enable in either register shows up as a shifted or missing out_vld, or as an out_prod that changes during an idle gap. Both are visible on the cycle after the gap begins.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    // Largest product width the height functions can track.
    localparam int MAXCOL = 128;

    // Number of output bits a column of h bits produces.
    function automatic int cnt_w(input int h);
        if (h <= 1) return h;
        return $clog2(h + 1);
    endfunction

    // Output bits actually kept for column c, capped at the product width.
    function automatic int eff_w(input int pw, input int h, input int c);
        int w;
        w = cnt_w(h);
        if (w > pw - c) w = pw - c;
        return w;
    endfunction

    // Height of column c in the partial-product triangle.
    function automatic int tri_h(input int aw, input int bw, input int c);
        int n;
        n = 0;
        for (int i = 0; i < aw; i++)
            if ((c - i >= 0) && (c - i < bw)) n++;
        return n;
    endfunction

    // Height of column c at the input of reduction stage s.
    function automatic int col_h(input int aw, input int bw, input int s, input int c);
        int cur [MAXCOL];
        int nxt [MAXCOL];
        int pw;
        pw = aw + bw;
        for (int k = 0; k < MAXCOL; k++) begin
            cur[k] = (k < pw) ? tri_h(aw, bw, k) : 0;
            nxt[k] = 0;
        end
        for (int st = 0; st < s; st++) begin
            for (int k = 0; k < pw; k++) begin
                nxt[k] = 0;
                for (int j = 0; j <= k; j++)
                    if (eff_w(pw, cur[k - j], k - j) > j) nxt[k]++;
            end
            for (int k = 0; k < pw; k++) cur[k] = nxt[k];
        end
        return cur[c];
    endfunction

    // True when bit j of column c-j in stage s lands in column c of stage s+1.
    function automatic bit lands(input int aw, input int bw, input int s, input int c, input int j);
        if (j > c) return 1'b0;
        return eff_w(aw + bw, col_h(aw, bw, s, c - j), c - j) > j;
    endfunction

    // Row index taken by that bit in column c of stage s+1.
    function automatic int slot(input int aw, input int bw, input int s, input int c, input int j);
        int n;
        n = 0;
        for (int q = 0; q < j; q++)
            if (lands(aw, bw, s, c, q)) n++;
        return n;
    endfunction

    // Number of counter stages before every column is at most two high.
    function automatic int n_red(input int aw, input int bw);
        int mx;
        for (int s = 0; s < 32; s++) begin
            mx = 0;
            for (int c = 0; c < aw + bw; c++)
                if (col_h(aw, bw, s, c) > mx) mx = col_h(aw, bw, s, c);
            if (mx <= 2) return s;
        end
        return 32;
    endfunction

endpackage

// File: rtl/pcm_cells.sv
module pcm_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (a & ci) | (b & ci);
endmodule

module pcm_ha (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);
    assign s  = a ^ b;
    assign co = a & b;
endmodule

// File: rtl/pcm_ones_cnt.sv
// Counts the ones among N inputs using half and full adders only.
// Larger counts are built by splitting the inputs into two smaller counters
// and adding their results, with the one leftover bit as the carry in.
module pcm_ones_cnt #(
    parameter int N  = 3,
    parameter int OW = 2
) (
    input  logic [N-1:0]  bits,
    output logic [OW-1:0] cnt
);
    generate
        if (N == 1) begin : g_one
            assign cnt = bits;
        end else if (N == 2) begin : g_two
            logic [1:0] full;
            pcm_ha u_ha (.a(bits[0]), .b(bits[1]), .s(full[0]), .co(full[1]));
            assign cnt = full[OW-1:0];
        end else if (N == 3) begin : g_three
            logic [1:0] full;
            pcm_fa u_fa (.a(bits[0]), .b(bits[1]), .ci(bits[2]), .s(full[0]), .co(full[1]));
            assign cnt = full[OW-1:0];
        end else begin : g_split
            localparam int NL = (N - 1) / 2;
            localparam int NR = N - 1 - NL;
            localparam int WL = pcm_pkg::cnt_w(NL);
            localparam int WR = pcm_pkg::cnt_w(NR);
            localparam int W  = WR;
            logic [WL-1:0] cl;
            logic [WR-1:0] cr;
            logic [W-1:0]  xl;
            logic [W:0]    cy;
            logic [W:0]    full;

            pcm_ones_cnt #(.N(NL), .OW(WL)) u_lo (.bits(bits[NL-1:0]),    .cnt(cl));
            pcm_ones_cnt #(.N(NR), .OW(WR)) u_hi (.bits(bits[N-2:NL]),    .cnt(cr));

            if (WL == W) begin : g_same
                assign xl = cl;
            end else begin : g_ext
                assign xl = {{(W - WL){1'b0}}, cl};
            end

            assign cy[0] = bits[N-1];
            for (genvar i = 0; i < W; i++) begin : g_add
                pcm_fa u_fa (.a(xl[i]), .b(cr[i]), .ci(cy[i]), .s(full[i]), .co(cy[i+1]));
            end
            assign full[W] = cy[W];
            assign cnt = full[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/pcm_cpa.sv
// Final ripple addition of the two remaining rows; the top bit keeps no carry.
module pcm_cpa #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W-1:0] cy;

    assign cy[0] = 1'b0;
    generate
        for (genvar i = 0; i < W - 1; i++) begin : g_bit
            pcm_fa u_fa (.a(x[i]), .b(y[i]), .ci(cy[i]), .s(sum[i]), .co(cy[i+1]));
        end
    endgenerate
    assign sum[W-1] = x[W-1] ^ y[W-1] ^ cy[W-1];
endmodule

// File: rtl/pcm_colred.sv
// Combinational partial-product generation and column reduction.
module pcm_colred #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    output logic [A_W+B_W-1:0] prod
);
    localparam int P_W = A_W + B_W;
    localparam int NS  = pcm_pkg::n_red(A_W, B_W);

    logic [P_W-1:0] row0;
    logic [P_W-1:0] row1;

    generate
        for (genvar s = 0; s <= NS; s++) begin : g_stg
            for (genvar c = 0; c < P_W; c++) begin : g_col
                localparam int H  = pcm_pkg::col_h(A_W, B_W, s, c);
                localparam int OW = pcm_pkg::eff_w(P_W, H, c);
                if (H > 0) begin : g_nz
                    logic [H-1:0] bits;

                    if (s == 0) begin : g_pp
                        localparam int LO = (c - B_W + 1 > 0) ? (c - B_W + 1) : 0;
                        for (genvar r = 0; r < H; r++) begin : g_r
                            assign bits[r] = a[LO + r] & b[c - LO - r];
                        end
                    end else begin : g_rt
                        for (genvar j = 0; j <= c; j++) begin : g_j
                            if (pcm_pkg::lands(A_W, B_W, s - 1, c, j)) begin : g_l
                                assign bits[pcm_pkg::slot(A_W, B_W, s - 1, c, j)] =
                                    g_stg[s-1].g_col[c-j].g_nz.g_ct.cnt[j];
                            end
                        end
                    end

                    if (s < NS) begin : g_ct
                        logic [OW-1:0] cnt;
                        pcm_ones_cnt #(.N(H), .OW(OW)) u_cnt (.bits(bits), .cnt(cnt));
                    end
                end
            end
        end

        for (genvar c = 0; c < P_W; c++) begin : g_fin
            localparam int HF = pcm_pkg::col_h(A_W, B_W, NS, c);
            if (HF == 0) begin : g_h0
                assign row0[c] = 1'b0;
                assign row1[c] = 1'b0;
            end else if (HF == 1) begin : g_h1
                assign row0[c] = g_stg[NS].g_col[c].g_nz.bits[0];
                assign row1[c] = 1'b0;
            end else begin : g_h2
                assign row0[c] = g_stg[NS].g_col[c].g_nz.bits[0];
                assign row1[c] = g_stg[NS].g_col[c].g_nz.bits[1];
            end
        end
    endgenerate

    pcm_cpa #(.W(P_W)) u_cpa (.x(row0), .y(row1), .sum(prod));
endmodule

// File: rtl/pcmul_top.sv
module pcmul_top #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [A_W-1:0]       in_a,
    input  logic [B_W-1:0]       in_b,
    output logic                 out_vld,
    output logic [A_W+B_W-1:0]   out_prod
);
    localparam int P_W = A_W + B_W;

    typedef struct packed {
        logic           op_vld;
        logic [A_W-1:0] op_a;
        logic [B_W-1:0] op_b;
        logic           res_vld;
        logic [P_W-1:0] res;
    } st_t;

    st_t            st_d;
    st_t            st_q;
    logic [P_W-1:0] prod_w;

    pcm_colred #(.A_W(A_W), .B_W(B_W)) u_red (
        .a    (st_q.op_a),
        .b    (st_q.op_b),
        .prod (prod_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.op_vld = in_vld;
        if (in_vld) begin
            st_d.op_a = in_a;
            st_d.op_b = in_b;
        end
        st_d.res_vld = st_q.op_vld;
        if (st_q.op_vld) begin
            st_d.res = prod_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.res_vld;
    assign out_prod = st_q.res;
endmodule

// File: rtl/pcmul_chk.sv
module pcmul_chk #(
    parameter int A_W = 4,
    parameter int B_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic [A_W-1:0]       in_a,
    input logic [B_W-1:0]       in_b,
    input logic                 out_vld,
    input logic [A_W+B_W-1:0]   out_prod
);
    localparam int P_W = A_W + B_W;

    // R1: outputs idle while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!out_vld && out_prod == '0);
        end
    end

    // R2: valid flag follows the input flag two edges later
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 out_vld);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ##1 !out_vld);

    // R3: a valid result equals the product of operands sampled two edges before
    a_r3_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> out_prod == (P_W'($past(in_a, 2)) * P_W'($past(in_b, 2))));

    // R4: product register holds while no new result arrives
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(out_prod));
endmodule

bind pcmul_top pcmul_chk #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/pcmul_top_test.sv
module pcmul_top_test;
    localparam int A_W    = 4;
    localparam int B_W    = 4;
    localparam int P_W    = A_W + B_W;
    localparam int PERIOD = 20;

    logic           clk    = 1'b0;
    logic           rst_n  = 1'b0;
    logic           in_vld = 1'b0;
    logic [A_W-1:0] in_a   = '0;
    logic [B_W-1:0] in_b   = '0;
    logic           out_vld;
    logic [P_W-1:0] out_prod;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic           h1_v = 1'b0;
    logic           h2_v = 1'b0;
    logic [P_W-1:0] h1_p = '0;
    logic [P_W-1:0] h2_p = '0;
    string          h1_t = "R1";
    string          h2_t = "R1";
    logic [P_W-1:0] exp_p = '0;

    always #(PERIOD / 2) clk = ~clk;

    pcmul_top #(.A_W(A_W), .B_W(B_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_vld  (out_vld),
        .out_prod (out_prod)
    );

    // Shift-and-add reference product.
    function automatic logic [P_W-1:0] ref_mul(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
        logic [P_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < A_W; i++)
            if (a[i]) acc = acc + (P_W'(b) << i);
        return acc;
    endfunction

    task automatic check(input string tag, input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Check outputs for the pair driven two negedges ago, then drive a new pair.
    task automatic step(input logic v, input logic [A_W-1:0] a, input logic [B_W-1:0] b, input string tag);
        @(negedge clk);
        if (h2_v) exp_p = h2_p;
        check({h2_t, " valid"},   P_W'(out_vld), P_W'(h2_v));
        check({h2_t, " product"}, out_prod,      exp_p);
        h2_v = h1_v;
        h2_p = h1_p;
        h2_t = h1_t;
        h1_v = v;
        h1_p = ref_mul(a, b);
        h1_t = tag;
        in_vld = v;
        in_a   = a;
        in_b   = b;
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check("R1 valid in reset",   P_W'(out_vld), '0);
        check("R1 product in reset", out_prod,      '0);
        rst_n = 1'b1;
        step(1'b0, '0, '0, "R1");
        step(1'b0, '0, '0, "R1");

        // R2: isolated pulse, then idle
        step(1'b1, 4'd5, 4'd3, "R2");
        step(1'b0, 4'd9, 4'd9, "R2");
        step(1'b0, 4'd2, 4'd7, "R2");
        step(1'b0, 4'd0, 4'd0, "R2");

        // R3: exhaustive sweep, back to back
        for (int a = 0; a < (1 << A_W); a++)
            for (int b = 0; b < (1 << B_W); b++)
                step(1'b1, A_W'(a), B_W'(b), "R3");

        // R7: single set bit in each operand
        for (int i = 0; i < A_W; i++)
            for (int j = 0; j < B_W; j++)
                step(1'b1, A_W'(1) << i, B_W'(1) << j, "R7");

        // R6: extremes
        step(1'b1, '1, '1, "R6");
        step(1'b1, '0, '1, "R6");
        step(1'b1, '1, '0, "R6");
        step(1'b1, '1, B_W'(1), "R6");

        // R5: random back-to-back burst
        for (int k = 0; k < 16; k++)
            step(1'b1, A_W'($urandom), B_W'($urandom), "R5");

        // R4: a product followed by ignored operands
        step(1'b1, 4'd13, 4'd11, "R4");
        for (int k = 0; k < 4; k++)
            step(1'b0, A_W'($urandom), B_W'($urandom), "R4");

        // R4 and R3: random valid pattern with gaps
        for (int k = 0; k < 60; k++) begin
            logic v;
            v = 1'($urandom);
            step(v, A_W'($urandom), B_W'($urandom), v ? "R3" : "R4");
        end

        step(1'b0, '0, '0, "R4");
        step(1'b0, '0, '0, "R4");
        step(1'b0, '0, '0, "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule